// File: doc/BRIEF.md
# UART Interrupt Request Controller

This block turns the event and status signals around a bus-attached UART into one active-low interrupt line. It keeps five pending flags: received character ready, transmit holding slot free, transmitter fully drained, peripheral status fallen, and clear-to-send risen. Each flag is raised by its own event. Each is dropped by the CPU access that services it, at a chosen edge of the bus timing pulse. The request line is low while any pending flag is both enabled and allowed through by the control bits.

The two external status lines arrive asynchronously, so they pass through a synchronizer before their edges are detected. All other inputs come from logic in the same clock domain: the receiver strobe, the transmitter level flags, the CPU access decodes and the timing pulse. The CPU access decodes must be held steady over the whole timing pulse. The serial shifter, baud generation and character error checks sit outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: `irq_n` is low exactly when `ctl_irq_en` is 1 and at least one pending flag is enabled. A flag is enabled if it is the holding-slot flag and `ctl_tx_req` is 1, or if it is any of the other four flags. The output is combinational from the flags and the two control bits.
- R2: A one-cycle pulse on `rx_char_stb` sets the received-character flag at that clock edge.
- R3: The received-character flag clears at the clock edge where `bus_tpb` is sampled 1 after having been 0 (leading edge), if `cpu_rd_data` is 1 in that cycle.
- R4: The holding-slot flag sets when `tx_hold_empty` goes from 0 to 1. It clears at a leading edge of `bus_tpb` while `cpu_rd_status` or `cpu_wr_char` is 1.
- R5: The drained flag sets when (`tx_hold_empty` AND `tx_shift_empty`) goes from 0 to 1. It clears under the same access as R4.
- R6: The peripheral flag sets three clock edges after `periph_stat` falls, counting from the first edge that samples the new value. It clears only at a trailing edge of `bus_tpb`, meaning the edge where `bus_tpb` is sampled 0 after 1, while `cpu_rd_status` is 1. A status read seen only at the leading edge leaves it set.
- R7: The clear-to-send flag sets three clock edges after `cts_in` rises, but only if `tx_hold_empty` and `tx_shift_empty` are both 1 in the detecting cycle. Otherwise the rise is dropped. It clears at a leading edge of `bus_tpb` while `cpu_rd_status` is 1.
- R8: While `ctl_irq_en` is 0, `irq_n` stays high whatever flags are pending. Pending flags are kept and drive the line once the bit returns to 1.
- R9: While `ctl_tx_req` is 0, a pending holding-slot flag alone does not pull `irq_n` low.
- R10: If a flag's set event and clear event fall in the same cycle, the flag ends up set.
- R11: A clock edge with `rst_n` low clears every flag and the edge history, so `irq_n` is high after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_char_stb | input | 1 | One-cycle pulse per received character |
| tx_hold_empty | input | 1 | Transmit holding register empty (level) |
| tx_shift_empty | input | 1 | Transmit shift register empty (level) |
| periph_stat | input | 1 | External peripheral status line, asynchronous |
| cts_in | input | 1 | External clear-to-send line, asynchronous |
| cpu_rd_data | input | 1 | CPU is reading receive data |
| cpu_rd_status | input | 1 | CPU is reading the status register |
| cpu_wr_char | input | 1 | CPU is writing a transmit character |
| bus_tpb | input | 1 | Bus timing pulse, synchronous to clk |
| ctl_irq_en | input | 1 | Control bit: interrupt enable |
| ctl_tx_req | input | 1 | Control bit: transmit request, gates holding-slot flag |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume three things: `bus_tpb`, the access decodes and the transmitter levels all change on clock edges, `rst_n` is low for at least one edge, and `periph_stat` and `cts_in` idle high and low during reset. The bench keeps within this by driving every input only at the falling clock edge. It holds the external lines at their idle levels through reset, and it keeps each access decode asserted for both cycles of a timing pulse. The random phase draws the asynchronous lines at a low toggle rate, so edges are spaced out yet still meet set and clear events in the same cycle.

// File: rtl/uart_irq_pkg.sv
// Package: indices and vector type for the interrupt cause flags.
// Assumes: each cause owns one bit position in a pending vector.
package uart_irq_pkg;
    localparam int CAUSE_RX   = 0;  // received character ready
    localparam int CAUSE_HOLD = 1;  // transmit holding slot free
    localparam int CAUSE_IDLE = 2;  // transmitter fully drained
    localparam int CAUSE_PS   = 3;  // peripheral status fell
    localparam int CAUSE_CTS  = 4;  // clear-to-send rose
    localparam int NUM_CAUSES = 5;

    typedef logic [NUM_CAUSES-1:0] cause_vec_t;
endpackage

// File: rtl/uart_irq_edge.sv
// Edge detector with optional synchronizer in front.
// Function: emits a one-cycle pulse when the (synchronized) input
//           shows the selected transition against its previous value.
// Assumes: SYNC_STAGES = 0 only for inputs already in the clk domain;
//          RST_VAL is the idle level of the input during reset.
module uart_irq_edge #(
    parameter int   SYNC_STAGES = 2,
    parameter logic RST_VAL     = 1'b0,
    parameter bit   DETECT_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_pulse
);
    logic settled;
    logic prev_q;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;

            // Shift the raw input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= {SYNC_STAGES{RST_VAL}};
                end else begin
                    sync_q[0] <= din;
                    for (int k = 1; k < SYNC_STAGES; k++) begin
                        sync_q[k] <= sync_q[k-1];
                    end
                end
            end

            assign settled = sync_q[SYNC_STAGES-1];
        end else begin : g_direct
            assign settled = din;
        end
    endgenerate

    // Remember the last settled value for the compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= settled;
        end
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_pulse = settled & ~prev_q;
        end else begin : g_fall
            assign edge_pulse = ~settled & prev_q;
        end
    endgenerate
endmodule

// File: rtl/uart_irq_cause_bank.sv
// Bank of pending flags, one per interrupt cause.
// Function: each bit is set by its set strobe and cleared by its clear
//           strobe; a set in the same cycle as a clear keeps the bit set.
// Assumes: strobes are synchronous to clk.
module uart_irq_cause_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            // Hold one cause flag; set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    pend[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    pend[i] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/uart_irq_ctrl.sv
// UART interrupt request controller (top).
// Function: detects the five interrupt causes, latches them, clears
//           each on its servicing CPU access at the proper edge of the
//           bus timing pulse, and drives an active-low request line.
// Assumes: all inputs except periph_stat and cts_in are synchronous to
//          clk; access decodes are held across the whole timing pulse.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_char_stb,
    input  logic tx_hold_empty,
    input  logic tx_shift_empty,
    input  logic periph_stat,
    input  logic cts_in,
    input  logic cpu_rd_data,
    input  logic cpu_rd_status,
    input  logic cpu_wr_char,
    input  logic bus_tpb,
    input  logic ctl_irq_en,
    input  logic ctl_tx_req,
    output logic irq_n
);
    logic       tpb_lead;
    logic       tpb_trail;
    logic       hold_rise;
    logic       idle_rise;
    logic       ps_fall;
    logic       cts_rise;
    logic       tx_idle;
    cause_vec_t set_vec;
    cause_vec_t clr_vec;
    cause_vec_t pend_q;
    cause_vec_t allow;

    assign tx_idle = tx_hold_empty & tx_shift_empty;

    uart_irq_edge #(.SYNC_STAGES(0), .RST_VAL(1'b0), .DETECT_RISE(1'b1)) u_tpb_lead (
        .clk(clk), .rst_n(rst_n), .din(bus_tpb), .edge_pulse(tpb_lead)
    );

    uart_irq_edge #(.SYNC_STAGES(0), .RST_VAL(1'b0), .DETECT_RISE(1'b0)) u_tpb_trail (
        .clk(clk), .rst_n(rst_n), .din(bus_tpb), .edge_pulse(tpb_trail)
    );

    uart_irq_edge #(.SYNC_STAGES(0), .RST_VAL(1'b0), .DETECT_RISE(1'b1)) u_hold (
        .clk(clk), .rst_n(rst_n), .din(tx_hold_empty), .edge_pulse(hold_rise)
    );

    uart_irq_edge #(.SYNC_STAGES(0), .RST_VAL(1'b0), .DETECT_RISE(1'b1)) u_idle (
        .clk(clk), .rst_n(rst_n), .din(tx_idle), .edge_pulse(idle_rise)
    );

    uart_irq_edge #(.SYNC_STAGES(SYNC_STAGES), .RST_VAL(1'b1), .DETECT_RISE(1'b0)) u_ps (
        .clk(clk), .rst_n(rst_n), .din(periph_stat), .edge_pulse(ps_fall)
    );

    uart_irq_edge #(.SYNC_STAGES(SYNC_STAGES), .RST_VAL(1'b0), .DETECT_RISE(1'b1)) u_cts (
        .clk(clk), .rst_n(rst_n), .din(cts_in), .edge_pulse(cts_rise)
    );

    // Map cause events and servicing accesses onto the flag bank.
    always_comb begin
        set_vec             = '0;
        clr_vec             = '0;
        set_vec[CAUSE_RX]   = rx_char_stb;
        set_vec[CAUSE_HOLD] = hold_rise;
        set_vec[CAUSE_IDLE] = idle_rise;
        set_vec[CAUSE_PS]   = ps_fall;
        set_vec[CAUSE_CTS]  = cts_rise & tx_idle;
        clr_vec[CAUSE_RX]   = tpb_lead & cpu_rd_data;
        clr_vec[CAUSE_HOLD] = tpb_lead & (cpu_rd_status | cpu_wr_char);
        clr_vec[CAUSE_IDLE] = tpb_lead & (cpu_rd_status | cpu_wr_char);
        clr_vec[CAUSE_PS]   = tpb_trail & cpu_rd_status;
        clr_vec[CAUSE_CTS]  = tpb_lead & cpu_rd_status;
    end

    uart_irq_cause_bank #(.N(NUM_CAUSES)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend_q)
    );

    // Per-cause gating by the control register bits.
    always_comb begin
        allow             = '1;
        allow[CAUSE_HOLD] = ctl_tx_req;
    end

    // Combine gated causes into the active-low request line.
    assign irq_n = ~(ctl_irq_en & (|(pend_q & allow)));
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Checker for uart_irq_ctrl, attached by bind.
// Function: temporal checks on the request line and the flag bank.
// Assumes: inputs change only on clock edges; reset lasts one edge or more.
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_char_stb,
    input logic       cpu_rd_data,
    input logic       cpu_rd_status,
    input logic       ctl_irq_en,
    input logic       ctl_tx_req,
    input logic       irq_n,
    input logic       tpb_lead,
    input logic       tpb_trail,
    input logic       ps_fall,
    input cause_vec_t pend_q
);
    cause_vec_t others;

    always_comb begin
        others             = pend_q;
        others[CAUSE_HOLD] = 1'b0;
    end

    // R2 and R10: a character strobe always leaves a pending request.
    a_r2_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char_stb |=> (!ctl_irq_en || !irq_n));

    // R3: a data read at the leading edge with no new character clears the flag.
    a_r3_rx_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tpb_lead && cpu_rd_data && !rx_char_stb) |=> !pend_q[CAUSE_RX]);

    // R6: a status read at the trailing edge with no new fall clears the flag.
    a_r6_ps_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tpb_trail && cpu_rd_status && !ps_fall) |=> !pend_q[CAUSE_PS]);

    // R8: enable bit low keeps the line high.
    a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_irq_en |-> irq_n);

    // R9: holding-slot flag alone is masked while transmit request is low.
    a_r9_txreq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_tx_req && others == '0) |-> irq_n);

    // R11: after a reset edge nothing is pending.
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (irq_n && pend_q == '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_char_stb(rx_char_stb),
    .cpu_rd_data(cpu_rd_data), .cpu_rd_status(cpu_rd_status),
    .ctl_irq_en(ctl_irq_en), .ctl_tx_req(ctl_tx_req), .irq_n(irq_n),
    .tpb_lead(tpb_lead), .tpb_trail(tpb_trail), .ps_fall(ps_fall),
    .pend_q(pend_q)
);

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_char_stb = 0, tx_hold_empty = 0, tx_shift_empty = 0;
    logic periph_stat = 1, cts_in = 0;
    logic cpu_rd_data = 0, cpu_rd_status = 0, cpu_wr_char = 0, bus_tpb = 0;
    logic ctl_irq_en = 1, ctl_tx_req = 1;
    logic irq_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    uart_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rx_char_stb(rx_char_stb),
        .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
        .periph_stat(periph_stat), .cts_in(cts_in),
        .cpu_rd_data(cpu_rd_data), .cpu_rd_status(cpu_rd_status),
        .cpu_wr_char(cpu_wr_char), .bus_tpb(bus_tpb),
        .ctl_irq_en(ctl_irq_en), .ctl_tx_req(ctl_tx_req), .irq_n(irq_n)
    );

    // Reference model built from the requirements.
    logic [1:0] m_ps, m_cts;
    logic m_ps_p, m_cts_p, m_hold_p, m_idle_p, m_tpb_p;
    logic [4:0] m_pend;

    always @(posedge clk) begin
        logic lead, trail, ps_f, cts_r;
        logic [4:0] s, c;
        if (!rst_n) begin
            m_ps <= 2'b11; m_ps_p <= 1; m_cts <= 2'b00; m_cts_p <= 0;
            m_hold_p <= 0; m_idle_p <= 0; m_tpb_p <= 0; m_pend <= '0;
        end else begin
            lead  = bus_tpb & ~m_tpb_p;
            trail = ~bus_tpb & m_tpb_p;
            ps_f  = ~m_ps[1] & m_ps_p;
            cts_r = m_cts[1] & ~m_cts_p;
            s[0] = rx_char_stb;
            s[1] = tx_hold_empty & ~m_hold_p;
            s[2] = (tx_hold_empty & tx_shift_empty) & ~m_idle_p;
            s[3] = ps_f;
            s[4] = cts_r & tx_hold_empty & tx_shift_empty;
            c[0] = lead & cpu_rd_data;
            c[1] = lead & (cpu_rd_status | cpu_wr_char);
            c[2] = c[1];
            c[3] = trail & cpu_rd_status;
            c[4] = lead & cpu_rd_status;
            m_pend   <= s | (m_pend & ~c);
            m_ps     <= {m_ps[0], periph_stat};  m_ps_p  <= m_ps[1];
            m_cts    <= {m_cts[0], cts_in};      m_cts_p <= m_cts[1];
            m_hold_p <= tx_hold_empty;
            m_idle_p <= tx_hold_empty & tx_shift_empty;
            m_tpb_p  <= bus_tpb;
        end
    end

    function automatic logic model_irq_n();
        logic [4:0] allow;
        allow = 5'b11111;
        allow[1] = ctl_tx_req;
        return ~(ctl_irq_en & (|(m_pend & allow)));
    endfunction

    task automatic chk(string tag, logic exp);
        n_checks++;
        if (irq_n !== exp) begin
            n_fails++;
            $display("FAIL %s: irq_n actual=%b expected=%b at %0t", tag, irq_n, exp, $time);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // Access over one full timing pulse: leading cycle, then trailing cycle.
    task automatic access(logic rd_d, logic rd_s, logic wr_c);
        cpu_rd_data = rd_d; cpu_rd_status = rd_s; cpu_wr_char = wr_c;
        bus_tpb = 1; tick();
        bus_tpb = 0; tick();
        cpu_rd_data = 0; cpu_rd_status = 0; cpu_wr_char = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        tick(3);
        rst_n = 1;
        chk("R11 reset state", 1'b1);

        // R2: character strobe
        rx_char_stb = 1; tick(); rx_char_stb = 0;
        chk("R2 rx set", 1'b0);
        // R3: data read clears
        access(1, 0, 0);
        chk("R3 rx cleared", 1'b1);

        // R9 / R4: holding-slot flag masked then visible
        ctl_tx_req = 0; tx_hold_empty = 1; tick();
        chk("R9 hold masked", 1'b1);
        ctl_tx_req = 1; tick();
        chk("R4 hold visible", 1'b0);
        access(0, 0, 1);
        chk("R4 hold cleared by write", 1'b1);

        // R5: drained flag
        tx_shift_empty = 1; tick();
        chk("R5 drained set", 1'b0);
        access(0, 1, 0);
        chk("R5 drained cleared", 1'b1);

        // R7: clear-to-send with three-edge latency
        cts_in = 1; tick(2);
        chk("R7 cts not yet", 1'b1);
        tick();
        chk("R7 cts set", 1'b0);
        access(0, 1, 0);
        chk("R7 cts cleared", 1'b1);
        cts_in = 0; tick(4);
        tx_shift_empty = 0; tick();
        cts_in = 1; tick(5);
        chk("R7 cts gated off when not idle", 1'b1);

        // R6: peripheral status fall, trailing-edge clear
        periph_stat = 0; tick(2);
        chk("R6 ps not yet", 1'b1);
        tick();
        chk("R6 ps set", 1'b0);
        cpu_rd_status = 1; bus_tpb = 1; tick();
        cpu_rd_status = 0; bus_tpb = 0; tick();
        chk("R6 ps kept after leading-only read", 1'b0);
        access(0, 1, 0);
        chk("R6 ps cleared at trailing", 1'b1);

        // R8: enable gate
        ctl_irq_en = 0; rx_char_stb = 1; tick(); rx_char_stb = 0; tick();
        chk("R8 disabled high", 1'b1);
        ctl_irq_en = 1; tick();
        chk("R8 pending kept", 1'b0);
        access(1, 0, 0);
        chk("R8 cleared", 1'b1);

        // R10: set and clear in the same cycle
        rx_char_stb = 1; cpu_rd_data = 1; bus_tpb = 1; tick();
        rx_char_stb = 0; bus_tpb = 0; tick(); cpu_rd_data = 0;
        chk("R10 set wins", 1'b0);
        access(1, 0, 0);
        chk("R10 later clear", 1'b1);

        // R1: random stimulus against the model
        for (int i = 0; i < 4000; i++) begin
            rx_char_stb = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 9) == 0) tx_hold_empty = ~tx_hold_empty;
            if ($urandom_range(0, 9) == 0) tx_shift_empty = ~tx_shift_empty;
            if ($urandom_range(0, 11) == 0) periph_stat = ~periph_stat;
            if ($urandom_range(0, 11) == 0) cts_in = ~cts_in;
            if (!bus_tpb) begin
                cpu_rd_data   = $urandom_range(0, 1);
                cpu_rd_status = $urandom_range(0, 1);
                cpu_wr_char   = $urandom_range(0, 1);
                bus_tpb       = ($urandom_range(0, 2) == 0);
            end else begin
                bus_tpb = 0;
            end
            ctl_irq_en = ($urandom_range(0, 5) != 0);
            ctl_tx_req = $urandom_range(0, 1);
            tick();
            chk("R1 random vs model", model_irq_n());
        end

        // R11: reset mid-run with pending causes
        rx_char_stb = 1; tick(); rx_char_stb = 0;
        rst_n = 0; tick(); rst_n = 1;
        chk("R11 reset clears", 1'b1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule